// File: doc/BRIEF.md
# Handshaken Bus Cycle Sequencer

This block is a bus master that runs one read or one write at a time on a 16-bit parallel bus. The bus has an active-low address strobe, a read/write line that is low for writes, one active-low data strobe per byte lane, and an active-low acknowledge returned by the slave. A local requester offers an address, write data, byte enables and a direction with a valid/ready pair. The sequencer then walks the bus through its fixed phases and returns read data with a one-state done pulse.

The block runs on a clock at twice the bus clock rate, so each clock period is one half-clock bus state. A cycle with no waits is eight states, S0 to S7. The acknowledge is brought in through a synchronizer and is looked at only at the end of S4. While it is absent, whole wait clocks (pairs of states) are added. The master does not begin a new cycle until it sees the acknowledge released, which protects against a slave that is slow to let go. An optional wait limit abandons a cycle whose acknowledge never comes.

Top module: `busCycleSeq`

## Requirements
- R1: With the acknowledge seen at the end of S4, a cycle lasts exactly eight states from the state after acceptance (S0) to the done state (S7). The address strobe is low in S2 to S6 and in any wait state. No data strobe is ever low while the address strobe is high.
- R2: Each time the acknowledge is absent at a sampling point (end of S4, or end of the second state of a wait pair), exactly two wait states are added, and sampling repeats at the end of that pair.
- R3: On a write, the read/write line goes low in S1, two states before the data bus drive enable rises in S3.
- R4: On a write, the data strobes go low in S4, one state after the data is driven. On a read, the data strobes go low together with the address strobe in S2.
- R5: On a write, the data is still driven and the read/write line is still low in S7, the state after the strobes negate. Both are released when the cycle ends.
- R6: A read captures the input data bus at the end of S6 and presents it on the response data with the done pulse in S7.
- R7: Byte-enable bit 1 drives strobe bit 1 (D15..D8) and bit 0 drives strobe bit 0 (D7..D0). A strobe whose enable is 0 stays high for the whole cycle.
- R8: The acknowledge passes through a two-flop synchronizer. On a write acknowledged in the same state its strobes fall, this gives exactly one wait clock, so the cycle lasts ten states.
- R9: Request ready is high only in the idle state, and only while the synchronized acknowledge reads released. A request is accepted on a clock edge where valid and ready are both high.
- R10: With a nonzero wait limit L, a cycle still unacknowledged after L wait clocks enters an abort state instead. In that state all strobes are high, the bus is not driven, and done and error are both high for one state. A limit of 0 never aborts.
- R11: After reset, all strobes are high, read/write is high, the bus is not driven, done and error are low, and ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bus half-state per period |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Request can be accepted this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 24 | Cycle address |
| reqWData | input | 16 | Write data |
| reqBe | input | 2 | Byte enables, bit 1 upper lane, bit 0 lower lane |
| wdLimit | input | 8 | Maximum wait clocks, 0 disables the limit |
| rspDone | output | 1 | One-state pulse at the end of a cycle |
| rspErr | output | 1 | Cycle was abandoned by the wait limit |
| rspData | output | 16 | Read data captured at the end of S6 |
| busAddr | output | 24 | Address bus |
| busAsN | output | 1 | Address strobe, active low |
| busRwN | output | 1 | High for read, low for write |
| busDsN | output | 2 | Data strobes per lane, active low |
| busDataOut | output | 16 | Write data onto the bus |
| busDataOe | output | 1 | Drive enable for busDataOut |
| busDataIn | input | 16 | Data bus read value |
| busAckN | input | 1 | Transfer acknowledge from slave, active low |

## Verification
A wrong control state shows up at once on the strobe pins. A phase that is off by one moves the edge of the address strobe, a data strobe or the read/write line in that same state. It also shifts the done pulse and the sampled read data by the same amount. A synchronizer fault or a wrong sampling point shows up as a wrong number of wait pairs, seen at the first sampling point. A release-check fault shows up as ready being high while the acknowledge is still low, or a later cycle ending early. The bench runs a behavioural phase model beside the block and compares every pin on every clock, so any such divergence is caught in the state where it first appears.

// File: rtl/busSeqPkg.sv
package busSeqPkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_S0, ST_S1, ST_S2, ST_S3, ST_S4, ST_S5, ST_S6, ST_S7,
    ST_WA, ST_WB, ST_ABORT
  } busState_t;

  typedef struct packed {
    logic load;        // latch a new request
    logic addrStrobe;  // address strobe active
    logic dataStrobe;  // data strobes active (lane-gated downstream)
    logic rwLow;       // read/write line low
    logic driveData;   // write data driven
    logic capture;     // sample read data
    logic done;        // cycle finished
    logic err;         // cycle abandoned
  } busCtrl_t;
endpackage

// File: rtl/busAckSync.sv
module busAckSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic ackInN,
  output logic ackSeen
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : gSingle
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain <= '1;
        else       chain <= ackInN;
    end else begin : gMulti
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain <= '1;
        else       chain <= {chain[STAGES-2:0], ackInN};
    end
  endgenerate

  assign ackSeen = ~chain[STAGES-1];
endmodule

// File: rtl/busSeqCtrl.sv
module busSeqCtrl
  import busSeqPkg::*;
#(
  parameter int WD_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic            reqWrite,
  output logic            reqReady,
  input  logic            ackSeen,
  input  logic [WD_W-1:0] wdLimit,
  output busCtrl_t        ctl
);
  busState_t state, nextState;
  logic isWrite;
  logic [WD_W-1:0] waitCnt;
  logic enterWait;

  assign reqReady = (state == ST_IDLE) && !ackSeen;

  // decision at an acknowledge sampling point
  always_comb begin
    nextState = state;
    enterWait = 1'b0;
    case (state)
      ST_IDLE: if (reqValid && reqReady) nextState = ST_S0;
      ST_S0:   nextState = ST_S1;
      ST_S1:   nextState = ST_S2;
      ST_S2:   nextState = ST_S3;
      ST_S3:   nextState = ST_S4;
      ST_S4, ST_WB: begin
        if (ackSeen)                                    nextState = ST_S5;
        else if (wdLimit != '0 && waitCnt == wdLimit)   nextState = ST_ABORT;
        else begin
          nextState = ST_WA;
          enterWait = 1'b1;
        end
      end
      ST_WA:   nextState = ST_WB;
      ST_S5:   nextState = ST_S6;
      ST_S6:   nextState = ST_S7;
      ST_S7:   nextState = ST_IDLE;
      ST_ABORT: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      isWrite <= 1'b0;
      waitCnt <= '0;
    end else begin
      state <= nextState;
      if (ctl.load) begin
        isWrite <= reqWrite;
        waitCnt <= '0;
      end else if (enterWait) begin
        waitCnt <= waitCnt + 1'b1;
      end
    end
  end

  logic inStrobe, inWait, lateWrite;
  always_comb begin
    inWait    = (state == ST_WA) || (state == ST_WB);
    inStrobe  = (state == ST_S2) || (state == ST_S3) || (state == ST_S4) ||
                (state == ST_S5) || (state == ST_S6) || inWait;
    lateWrite = (state == ST_S4) || (state == ST_S5) || (state == ST_S6) || inWait;
    ctl            = '0;
    ctl.load       = reqValid && reqReady;
    ctl.addrStrobe = inStrobe;
    ctl.dataStrobe = isWrite ? lateWrite : inStrobe;
    ctl.rwLow      = isWrite && (state != ST_IDLE) && (state != ST_S0) && (state != ST_ABORT);
    ctl.driveData  = isWrite && (lateWrite || (state == ST_S3) || (state == ST_S7));
    ctl.capture    = (state == ST_S6) && !isWrite;
    ctl.done       = (state == ST_S7) || (state == ST_ABORT);
    ctl.err        = (state == ST_ABORT);
  end

  // R9: a cycle only starts after the acknowledge was seen released
  assert_start_after_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_S0) |-> $past(!ackSeen));
  // R2: wait states come in pairs
  assert_wait_pair_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WB) |-> $past(state == ST_WA));
  // R2: data phase only after the acknowledge was sampled
  assert_ack_before_s5_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_S5) |-> $past(ackSeen));
  // R10: the wait count never passes a nonzero limit
  assert_wait_bound_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WA && $stable(wdLimit) && wdLimit != '0) |-> (waitCnt <= wdLimit));
endmodule

// File: rtl/busSeqData.sv
module busSeqData
  import busSeqPkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  busCtrl_t          ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWData,
  input  logic [LANES-1:0]  reqBe,
  input  logic [DATA_W-1:0] busDataIn,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busDataOut,
  output logic [LANES-1:0]  busDsN,
  output logic [DATA_W-1:0] rspData
);
  logic [LANES-1:0] beReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busAddr    <= '0;
      busDataOut <= '0;
      beReg      <= '0;
      rspData    <= '0;
    end else begin
      if (ctl.load) begin
        busAddr    <= reqAddr;
        busDataOut <= reqWData;
        beReg      <= reqBe;
      end
      if (ctl.capture) rspData <= busDataIn;
    end
  end

  for (genvar lane = 0; lane < LANES; lane++) begin : gLane
    assign busDsN[lane] = ~(ctl.dataStrobe & beReg[lane]);
  end

  // R7: a lane strobe is only active when its enable was latched
  assert_lane_enable_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busDsN != '1) |-> ((~busDsN & ~beReg) == '0));
endmodule

// File: rtl/busCycleSeq.sv
module busCycleSeq
  import busSeqPkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int WD_W   = 8,
  parameter int SYNC_STAGES = 2,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWData,
  input  logic [LANES-1:0]  reqBe,
  input  logic [WD_W-1:0]   wdLimit,
  output logic              rspDone,
  output logic              rspErr,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busAsN,
  output logic              busRwN,
  output logic [LANES-1:0]  busDsN,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe,
  input  logic [DATA_W-1:0] busDataIn,
  input  logic              busAckN
);
  busCtrl_t ctl;
  logic ackSeen;

  busAckSync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .ackInN(busAckN), .ackSeen(ackSeen));

  busSeqCtrl #(.WD_W(WD_W)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .ackSeen(ackSeen), .wdLimit(wdLimit), .ctl(ctl));

  busSeqData #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqAddr(reqAddr), .reqWData(reqWData),
    .reqBe(reqBe), .busDataIn(busDataIn), .busAddr(busAddr),
    .busDataOut(busDataOut), .busDsN(busDsN), .rspData(rspData));

  assign busAsN    = ~ctl.addrStrobe;
  assign busRwN    = ~ctl.rwLow;
  assign busDataOe = ctl.driveData;
  assign rspDone   = ctl.done;
  assign rspErr    = ctl.err;

  // R1: data strobes only inside the address strobe
  assert_ds_inside_as_R1: assert property (@(posedge clk) disable iff (!rstN)
    (busDsN != '1) |-> !busAsN);
  // R3: drive enable rises only after read/write is already low
  assert_rw_before_drive_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busDataOe) |-> $past(!busRwN));
  // R4: write strobes fall only with data already driven
  assert_data_before_ds_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((busDsN != '1) && ($past(busDsN) == '1) && !busRwN) |-> $past(busDataOe));
  // R5: write data held for a state after the strobes negate
  assert_hold_after_ds_R5: assert property (@(posedge clk) disable iff (!rstN)
    (($past(busDsN) != '1) && (busDsN == '1) && !rspErr && $past(!busRwN)) |-> busDataOe);
  // R10: an abandoned cycle releases every strobe
  assert_abort_release_R10: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> (rspDone && busAsN && busDsN == '1 && !busDataOe));
endmodule

// File: tb/tb_busCycleSeq.sv
module tb_busCycleSeq;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [23:0] reqAddr = '0;
  logic [15:0] reqWData = '0;
  logic [1:0]  reqBe = 2'b11;
  logic [7:0]  wdLimit = '0;
  logic reqReady, rspDone, rspErr, busAsN, busRwN, busDataOe;
  logic [15:0] rspData, busDataOut;
  logic [15:0] busDataIn = '0;
  logic [23:0] busAddr;
  logic [1:0]  busDsN;
  logic busAckN = 1'b1;

  always #2 clk = ~clk;  // 250 MHz

  busCycleSeq dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWData(reqWData), .reqBe(reqBe),
    .wdLimit(wdLimit), .rspDone(rspDone), .rspErr(rspErr), .rspData(rspData),
    .busAddr(busAddr), .busAsN(busAsN), .busRwN(busRwN), .busDsN(busDsN),
    .busDataOut(busDataOut), .busDataOe(busDataOe), .busDataIn(busDataIn),
    .busAckN(busAckN));

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- slave model ----------------
  int sAckLat = 0, sRelLat = 0, sCnt = 0, sRel = 0;
  always @(negedge clk) begin
    if (!rstN) begin
      busAckN <= 1'b1; sCnt = 0; sRel = 0;
    end else if (busDsN != 2'b11) begin
      if (sCnt == sAckLat) busAckN <= 1'b0;
      sCnt++; sRel = 0;
    end else begin
      sCnt = 0;
      if (!busAckN) begin
        if (sRel >= sRelLat) busAckN <= 1'b1;
        else sRel++;
      end
    end
  end

  // ---------------- behavioural reference ----------------
  // phase: -1 idle, 0..7 main states, 10/11 wait pair, 12 abort
  int mPhase = -1, mWaits = 0;
  logic mS1 = 1'b1, mS2 = 1'b1, mWr = 1'b0;
  logic [1:0] mBe = '0;
  logic [23:0] mAddr = '0;
  logic [15:0] mWd = '0, mRd = '0;

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = -1; mS1 = 1'b1; mS2 = 1'b1; mWaits = 0; mRd = '0;
    end else begin
      logic oldS2;
      oldS2 = mS2;
      mS2 = mS1;
      mS1 = busAckN;
      if (mPhase == 6 && !mWr) mRd = busDataIn;
      case (mPhase)
        -1: if (reqValid && oldS2) begin
              mPhase = 0; mWr = reqWrite; mBe = reqBe; mAddr = reqAddr;
              mWd = reqWData; mWaits = 0;
            end
        0, 1, 2, 3, 5, 6: mPhase++;
        10: mPhase = 11;
        4, 11: begin
          if (!oldS2) mPhase = 5;
          else if (wdLimit != 0 && mWaits == int'(wdLimit)) mPhase = 12;
          else begin mWaits++; mPhase = 10; end
        end
        default: mPhase = -1;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      bit span, dsOn, wt;
      wt   = (mPhase == 10) || (mPhase == 11);
      span = (mPhase >= 2 && mPhase <= 6) || wt;
      dsOn = mWr ? ((mPhase >= 4 && mPhase <= 6) || wt) : span;
      chk(busAsN == !span, "R1", "address strobe", busAsN, !span);
      chk(busDsN == ~({2{dsOn}} & mBe), "R7", "data strobes", busDsN, ~({2{dsOn}} & mBe));
      chk(busRwN == !(mWr && ((mPhase >= 1 && mPhase <= 7) || wt)), "R3", "read/write",
          busRwN, !(mWr && ((mPhase >= 1 && mPhase <= 7) || wt)));
      chk(busDataOe == (mWr && ((mPhase >= 3 && mPhase <= 7) || wt)), "R4", "drive enable",
          busDataOe, (mWr && ((mPhase >= 3 && mPhase <= 7) || wt)));
      chk(rspDone == (mPhase == 7 || mPhase == 12), "R2", "done", rspDone,
          (mPhase == 7 || mPhase == 12));
      chk(rspErr == (mPhase == 12), "R10", "error", rspErr, (mPhase == 12));
      chk(reqReady == (mPhase < 0 && mS2), "R9", "ready", reqReady, (mPhase < 0 && mS2));
      if (mPhase >= 0) chk(busAddr == mAddr, "R1", "address", busAddr, mAddr);
      if (busDataOe) chk(busDataOut == mWd, "R5", "write data", busDataOut, mWd);
      if (mPhase == 7 && !mWr) chk(rspData == mRd, "R6", "read data", rspData, mRd);
    end
  end

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- transaction driver ----------------
  task automatic doTxn(input bit w, input logic [1:0] be, input logic [23:0] a,
                       input logic [15:0] d, input logic [15:0] slaveData,
                       input int ackLat, input int relLat, input int expLen,
                       input bit expErr, input string req);
    int len;
    @(negedge clk);
    reqWrite = w; reqBe = be; reqAddr = a; reqWData = d;
    busDataIn = slaveData; sAckLat = ackLat; sRelLat = relLat;
    reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    len = 1;
    while (!rspDone) begin
      @(negedge clk);
      len++;
    end
    if (expLen > 0) chk(len == expLen, req, "cycle length", len, expLen);
    chk(rspErr == expErr, req, "error flag at done", rspErr, expErr);
    if (!w && !expErr) chk(rspData == slaveData, req, "returned read data", rspData, slaveData);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(busAsN == 1'b1, "R11", "reset address strobe", busAsN, 1);
    chk(busDsN == 2'b11, "R11", "reset data strobes", busDsN, 2'b11);
    chk(busRwN == 1'b1, "R11", "reset read/write", busRwN, 1);
    chk(busDataOe == 1'b0, "R11", "reset drive", busDataOe, 0);
    chk(rspDone == 1'b0 && rspErr == 1'b0, "R11", "reset done/err", {rspDone, rspErr}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1, "R11", "ready after reset", reqReady, 1);

    doTxn(0, 2'b11, 24'h001234, 16'h0000, 16'hBEEF, 0, 0, 8, 0, "R1");    // R1 R6 word read
    doTxn(1, 2'b11, 24'h002000, 16'hCAFE, 16'h0000, 0, 0, 10, 0, "R8");   // R8 sync delay
    doTxn(1, 2'b10, 24'h003001, 16'hA500, 16'h0000, 4, 0, -1, 0, "R7");   // R7 upper byte
    doTxn(0, 2'b01, 24'h004003, 16'h0000, 16'h005A, 3, 0, -1, 0, "R7");   // R7 lower byte
    doTxn(0, 2'b11, 24'h005000, 16'h0000, 16'h1357, 0, 7, 8, 0, "R9");    // slow release
    doTxn(0, 2'b11, 24'h005002, 16'h0000, 16'h2468, 0, 0, -1, 0, "R9");   // held off
    wdLimit = 8'd2;
    doTxn(1, 2'b11, 24'h006000, 16'h7777, 16'h0000, 1000, 0, 10, 1, "R10"); // abort
    doTxn(0, 2'b11, 24'h006100, 16'h0000, 16'h4321, 2, 0, -1, 0, "R10");   // within limit
    wdLimit = 8'd0;
    doTxn(1, 2'b01, 24'h007000, 16'h00C3, 16'h0000, 25, 2, -1, 0, "R2");   // long waits
    for (int i = 0; i < 24; i++) begin
      doTxn(i[0], (i % 3 == 0) ? 2'b11 : ((i % 3 == 1) ? 2'b10 : 2'b01),
            24'h010000 + 24'(i * 2), 16'(16'h1111 * i), 16'(16'hF00F ^ (i * 7)),
            i % 6, i % 4, -1, 0, "R2");
    end
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule